// File: doc/BRIEF.md
# Frame and Multiframe Sync Generator

This block derives two timing references from a single output clock. The frame output repeats every `CYCLES_PER_FRAME` input cycles (one 125 µs frame, for example 193 cycles at 1.544 MHz). The multiframe output repeats every four frames (500 µs) and is phase-aligned to every fourth frame boundary.

Each output has three control bits:
- an enable bit,
- a mode bit that selects a 50% square wave or a one-cycle active-low strobe,
- an invert bit that flips the polarity.

One free-running position counter and a 2-bit frame index give the timing for both outputs, so the two outputs can never drift apart. Both outputs come from flip-flops, so they are glitch-free. A change to a control bit acts on the next clock edge and never restarts the counters.

Strobe mode is meant for input clocks of 1.544 MHz or faster. At a slower clock, a one-cycle strobe no longer fits the frame timing that downstream logic expects.

Top module: `frame_sync_gen`

## Requirements
- R1: When an output's enable bit is 0, that output is driven low whatever its mode and invert bits are.
- R2: With the frame output enabled, in square mode and not inverted, it is high for the first floor(N/2) cycles of each frame and low for the remaining cycles, where N is `CYCLES_PER_FRAME`.
- R3: With the frame output enabled, in strobe mode and not inverted, it is low for exactly one cycle at frame position 0 and high for every other cycle.
- R4: Setting an output's invert bit gives the exact complement of the uninverted waveform, in both modes, while the output is enabled.
- R5: With the multiframe output enabled, in square mode and not inverted, it is high for frames 0 and 1 of each group of four (2N cycles) and low for frames 2 and 3 (2N cycles).
- R6: The frame position advances by one each clock, wraps from N-1 to 0, and every frame lasts exactly N cycles. The first rising edge after reset release produces the output for position 0 of frame 0.
- R7: With the multiframe output enabled, in strobe mode and not inverted, it is low for exactly one cycle at position 0 of frame 0 of each group of four. That cycle is the same one in which a frame strobe falls, once every 4N cycles.
- R8: A change to an enable, mode or invert bit takes effect on the output after the next rising edge and does not move the frame position or the frame index.
- R9: While reset is asserted (`rst_n` low) both outputs are low, and releasing reset restarts both counters at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-domain clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_en_i | input | 1 | Frame output enable |
| frm_pulse_i | input | 1 | Frame mode: 0 = square wave, 1 = one-cycle low strobe |
| frm_inv_i | input | 1 | Frame polarity invert |
| mf_en_i | input | 1 | Multiframe output enable |
| mf_pulse_i | input | 1 | Multiframe mode: 0 = square wave, 1 = one-cycle low strobe |
| mf_inv_i | input | 1 | Multiframe polarity invert |
| frm_sync_o | output | 1 | Frame sync (period N cycles) |
| mf_sync_o | output | 1 | Multiframe sync (period 4N cycles) |

## Verification
The bench runs two copies of the block, one with an odd frame length and one with an even frame length.
- Odd frame length: an off-by-one in the high/low split would show as a 5/4 split where 4/5 is expected.
- Multiframe strobe: a strobe on the wrong frame index would show as a low cycle in a frame where the reference model expects high.
- Control changes: control bits are toggled every few cycles. A design that reset its counters on a mode change, or applied a change one cycle late, would show a shifted waveform at the next frame boundary.
- Mid-run reset: a reset in the middle of a run checks that a design which failed to clear its frame index would misalign the multiframe strobe.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    // Number of frames in one multiframe; the 2-bit index depends on this.
    localparam int FRAMES_PER_MULTI = 4;
    localparam int FIDX_W           = $clog2(FRAMES_PER_MULTI);
    localparam int NUM_CH           = 2;

    typedef enum int {
        CH_FRAME = 0,
        CH_MULTI = 1
    } sync_ch_e;

    // Decoded timing for one output channel.
    typedef struct packed {
        logic level;   // square-wave level, uninverted
        logic strobe;  // boundary cycle for strobe mode
    } sync_timing_t;

endpackage

// File: rtl/fsg_position_counter.sv
module fsg_position_counter
    import fsg_pkg::*;
#(
    parameter int CYCLES_PER_FRAME = 193,
    localparam int CW = (CYCLES_PER_FRAME > 1) ? $clog2(CYCLES_PER_FRAME) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [CW-1:0]     pos_o,
    output logic [FIDX_W-1:0] fidx_o
);

    localparam logic [CW-1:0] LAST = CW'(CYCLES_PER_FRAME - 1);

    typedef struct packed {
        logic [CW-1:0]     pos;
        logic [FIDX_W-1:0] fidx;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pos == LAST) begin
            st_d.pos  = '0;
            st_d.fidx = st_q.fidx + FIDX_W'(1);
        end else begin
            st_d.pos = st_q.pos + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o  = st_q.pos;
    assign fidx_o = st_q.fidx;

    // R6: position wraps after the last cycle of a frame
    a_r6_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_o == LAST) |=> (pos_o == '0));

    // R6: position steps by one inside a frame
    a_r6_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_o != LAST) |=> (pos_o == $past(pos_o) + CW'(1)));

    // R7: frame index advances exactly at a frame wrap
    a_r7_fidx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_o == LAST) |=> (fidx_o == $past(fidx_o) + FIDX_W'(1)));

    a_r7_fidx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_o != LAST) |=> $stable(fidx_o));

endmodule

// File: rtl/fsg_sync_shaper.sv
module fsg_sync_shaper
    import fsg_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         pulse_i,
    input  logic         inv_i,
    input  sync_timing_t tim_i,
    output logic         sync_o
);

    typedef struct packed {
        logic sync;
    } shp_state_t;

    shp_state_t st_d, st_q;
    logic       raw;

    always_comb begin
        raw  = pulse_i ? ~tim_i.strobe : tim_i.level;
        st_d = st_q;
        if (en_i) begin
            st_d.sync = raw ^ inv_i;
        end else begin
            st_d.sync = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.sync;

    // R1: a disabled channel is low after the next edge
    a_r1_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !sync_o);

    // R3: with steady strobe settings a low cycle is followed by high
    a_r3_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable({en_i, pulse_i, inv_i}) && en_i && pulse_i && !inv_i && !sync_o)
        |=> sync_o);

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
    import fsg_pkg::*;
#(
    parameter int CYCLES_PER_FRAME = 193
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frm_en_i,
    input  logic frm_pulse_i,
    input  logic frm_inv_i,
    input  logic mf_en_i,
    input  logic mf_pulse_i,
    input  logic mf_inv_i,
    output logic frm_sync_o,
    output logic mf_sync_o
);

    localparam int CW   = (CYCLES_PER_FRAME > 1) ? $clog2(CYCLES_PER_FRAME) : 1;
    localparam int HALF = CYCLES_PER_FRAME / 2;
    localparam int MF_HALF = FRAMES_PER_MULTI / 2;

    logic [CW-1:0]       pos;
    logic [FIDX_W-1:0]   fidx;
    sync_timing_t        tim  [NUM_CH];
    logic [NUM_CH-1:0]   en_v, pulse_v, inv_v, sync_v;

    initial begin
        if (CYCLES_PER_FRAME < 2) begin
            $error("CYCLES_PER_FRAME must be at least 2");
        end
    end

    fsg_position_counter #(
        .CYCLES_PER_FRAME(CYCLES_PER_FRAME)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .pos_o  (pos),
        .fidx_o (fidx)
    );

    always_comb begin
        tim[CH_FRAME].level  = (pos < CW'(HALF));
        tim[CH_FRAME].strobe = (pos == '0);
        tim[CH_MULTI].level  = (fidx < FIDX_W'(MF_HALF));
        tim[CH_MULTI].strobe = (pos == '0) && (fidx == '0);
    end

    assign en_v    = {mf_en_i,    frm_en_i};
    assign pulse_v = {mf_pulse_i, frm_pulse_i};
    assign inv_v   = {mf_inv_i,   frm_inv_i};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        fsg_sync_shaper u_shaper (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (en_v[g]),
            .pulse_i (pulse_v[g]),
            .inv_i   (inv_v[g]),
            .tim_i   (tim[g]),
            .sync_o  (sync_v[g])
        );
    end

    assign frm_sync_o = sync_v[CH_FRAME];
    assign mf_sync_o  = sync_v[CH_MULTI];

    // R7: with both channels strobing uninverted, a multiframe low lines up with a frame low
    a_r7_mf_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable({frm_en_i, frm_pulse_i, frm_inv_i, mf_en_i, mf_pulse_i, mf_inv_i})
         && frm_en_i && frm_pulse_i && !frm_inv_i
         && mf_en_i && mf_pulse_i && !mf_inv_i && !mf_sync_o)
        |-> !frm_sync_o);

endmodule

// File: tb/frame_sync_gen_bench.sv
`timescale 1ns/1ps
module frame_sync_gen_bench;

    localparam int N_ODD  = 9;
    localparam int N_EVEN = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] en = '0, pm = '0, inv = '0;   // bit0 = frame, bit1 = multiframe
    logic [1:0] so_odd, so_even;

    always #2.5 clk = ~clk;

    frame_sync_gen #(.CYCLES_PER_FRAME(N_ODD)) u_frame_sync_gen (
        .clk(clk), .rst_n(rst_n),
        .frm_en_i(en[0]), .frm_pulse_i(pm[0]), .frm_inv_i(inv[0]),
        .mf_en_i(en[1]), .mf_pulse_i(pm[1]), .mf_inv_i(inv[1]),
        .frm_sync_o(so_odd[0]), .mf_sync_o(so_odd[1])
    );

    frame_sync_gen #(.CYCLES_PER_FRAME(N_EVEN)) u_frame_sync_gen_even (
        .clk(clk), .rst_n(rst_n),
        .frm_en_i(en[0]), .frm_pulse_i(pm[0]), .frm_inv_i(inv[0]),
        .mf_en_i(en[1]), .mf_pulse_i(pm[1]), .mf_inv_i(inv[1]),
        .frm_sync_o(so_even[0]), .mf_sync_o(so_even[1])
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // ---------------- behavioural reference ----------------
    int         k = 0;
    logic [1:0] exp_odd = '0, exp_even = '0;
    string      tag_odd [2] = '{"R9", "R9"};
    string      tag_even[2] = '{"R9", "R9"};
    logic [5:0] prev_ctrl = '0;

    function automatic bit model(int n, int p, int ch, bit e, bit pls, bit iv);
        int period;
        int q;
        bit raw;
        period = (ch == 0) ? n : 4 * n;
        q      = p % period;
        if (!e) return 1'b0;
        raw = pls ? (q != 0) : (q < period / 2);
        return raw ^ iv;
    endfunction

    function automatic string make_tag(int n, int p, int ch, bit e, bit pls, bit iv, bit chg);
        string s;
        if (!e)            s = "R1";
        else if (ch == 0)  s = pls ? "R3" : "R2";
        else               s = pls ? "R7" : "R5";
        if (e && iv)       s = {s, "/R4"};
        if (chg)           s = {s, "/R8"};
        if (p % n == 0)    s = {s, "/R6"};
        return s;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            k         = 0;
            exp_odd   = '0;
            exp_even  = '0;
            for (int c = 0; c < 2; c++) begin
                tag_odd[c]  = "R9";
                tag_even[c] = "R9";
            end
            prev_ctrl = {en, pm, inv};
        end else begin
            bit chg;
            chg       = ({en, pm, inv} != prev_ctrl);
            prev_ctrl = {en, pm, inv};
            for (int c = 0; c < 2; c++) begin
                exp_odd[c]  = model(N_ODD,  k, c, en[c], pm[c], inv[c]);
                exp_even[c] = model(N_EVEN, k, c, en[c], pm[c], inv[c]);
                tag_odd[c]  = make_tag(N_ODD,  k, c, en[c], pm[c], inv[c], chg);
                tag_even[c] = make_tag(N_EVEN, k, c, en[c], pm[c], inv[c], chg);
            end
            k++;
        end
    end

    // ---------------- comparison ----------------
    task automatic check_all();
        for (int c = 0; c < 2; c++) begin
            n_tests++;
            if (so_odd[c] !== exp_odd[c]) begin
                n_fail++;
                $display("FAIL %s odd ch=%0d actual=%b expected=%b t=%0t",
                         tag_odd[c], c, so_odd[c], exp_odd[c], $time);
            end
            n_tests++;
            if (so_even[c] !== exp_even[c]) begin
                n_fail++;
                $display("FAIL %s even ch=%0d actual=%b expected=%b t=%0t",
                         tag_even[c], c, so_even[c], exp_even[c], $time);
            end
        end
    endtask

    task automatic phase(logic [1:0] e, logic [1:0] p, logic [1:0] i, int cyc);
        @(negedge clk);
        check_all();
        en  = e;
        pm  = p;
        inv = i;
        for (int c = 1; c < cyc; c++) begin
            @(negedge clk);
            check_all();
        end
    endtask

    task automatic do_reset(int cyc);
        @(negedge clk);
        check_all();
        rst_n = 1'b0;
        for (int c = 0; c < cyc; c++) begin
            @(negedge clk);
            check_all();   // R9: outputs low in reset
        end
        rst_n = 1'b1;
    endtask

    initial begin
        // R9: reset state
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check_all();
        end
        rst_n = 1'b1;

        phase(2'b00, 2'b11, 2'b11, 20);   // R1 disabled, other bits set
        phase(2'b11, 2'b00, 2'b00, 80);   // R2, R5 square
        phase(2'b11, 2'b11, 2'b00, 80);   // R3, R7 strobe
        phase(2'b11, 2'b00, 2'b11, 80);   // R4 inverted square
        phase(2'b11, 2'b11, 2'b11, 80);   // R4 inverted strobe
        phase(2'b01, 2'b10, 2'b10, 40);   // frame only
        phase(2'b10, 2'b01, 2'b01, 40);   // multiframe only
        for (int r = 0; r < 80; r++) begin // R8 frequent changes
            phase(2'($urandom), 2'($urandom), 2'($urandom), 1 + int'($urandom % 7));
        end
        do_reset(3);                       // R9 mid-run reset
        phase(2'b11, 2'b11, 2'b00, 80);   // R6, R7 realignment after reset
        @(negedge clk);
        check_all();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R9 actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule